// File: doc/BRIEF.md
# Cartridge Slot Power Sequencer

This block sequences power for a removable cartridge slot. It has four states: off, powered-in-reset, ready and timed power-down. From the current state it drives the slot supply enable, an active-low card reset and a card clock enable. Software moves the slot between states by writing a 2-bit request. The block also watches a card-detect input. When the card is missing or pulled out, it sends the slot to the power-down state. That state falls back to off after a fixed number of timer ticks.

The block keeps an interface-enable bit that software can write. The card leaves reset only when this bit is set and the slot is ready. The bit does not gate the clock. The block clears the bit by itself each time the slot drops to off. A one-cycle card interrupt marks each return to off from a powered state, and each power-up request refused because no card is present. While the card cannot answer, read data from the slot is replaced with a fixed pattern.

Top module: `slot_pwr_seq`

## Requirements
- R1: After reset the state is off (state_o = 0): power, clock, reset release, interrupt and interface enable are all low, and read data is zero.
- R2: In state off (code 0), pwr_en_o = 0, card_rst_no = 0, card_clk_en_o = 0 and rd_data_o = 0.
- R3: In state hold (code 1), pwr_en_o = 1, card_rst_no = 0, card_clk_en_o = 0 and rd_data_o is all ones.
- R4: In state ready (code 2), pwr_en_o = 1, card_clk_en_o = 1 and rd_data_o equals rd_data_i.
- R5: In state power-down (code 3), pwr_en_o = 1, card_rst_no = 0, card_clk_en_o = 0 and rd_data_o = 0.
- R6: A request for code 1 or 2 while card_present_i = 0 moves the state to code 3 and gives a one-cycle card_irq_o pulse.
- R7: If card_present_i is low while the state is code 1 or 2, the next state is code 3, with no interrupt.
- R8: State code 3 moves to code 0 on the OFF_TICKS-th tick_i pulse seen while in code 3. Ticks outside code 3 have no effect.
- R9: Each entry into code 0 from codes 1, 2 or 3 gives a one-cycle card_irq_o pulse and clears if_en_o. This clear wins over a software write to the bit in the same cycle.
- R10: card_rst_no is high only in code 2 with if_en_o = 1. If if_en_o = 0 in code 2, card_clk_en_o stays 1.
- R11: While in code 0, a request for code 3 is ignored, and a request for code 0 raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_wr_i | input | 1 | Strobe for a state request |
| state_req_i | input | 2 | Requested state code (0 off, 1 hold, 2 ready, 3 power-down) |
| card_present_i | input | 1 | Card detect, high when a card is inserted |
| if_en_wr_i | input | 1 | Strobe for a write to the interface-enable bit |
| if_en_i | input | 1 | Value written to the interface-enable bit |
| tick_i | input | 1 | Power-down timer tick |
| state_o | output | 2 | Current state code |
| if_en_o | output | 1 | Current interface-enable bit |
| pwr_en_o | output | 1 | Slot supply enable |
| card_rst_no | output | 1 | Card reset, active low |
| card_clk_en_o | output | 1 | Card clock enable |
| card_irq_o | output | 1 | Card interrupt pulse |
| rd_data_i | input | DATA_W | Read data from the card |
| rd_data_o | output | DATA_W | Read data after substitution |

## Verification
The assertions check on every cycle that the output pins agree with the state. They also check that reset is never released without the clock and the enable bit, that every drop to off comes with an interrupt and a cleared enable bit, and that a card pulled from a hold or ready slot leads to power-down. The bench scenarios cover the rest: the exact tick count of the power-down timer, the interrupt on a power-up request refused for lack of a card, the clear of the enable bit winning over a same-cycle write, and requests that are ignored while off.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
  typedef enum logic [1:0] {
    SLOT_OFF   = 2'd0,
    SLOT_HOLD  = 2'd1,
    SLOT_READY = 2'd2,
    SLOT_PDOWN = 2'd3
  } slot_st_e;
endpackage

// File: rtl/slot_down_timer.sv
module slot_down_timer #(
  parameter int unsigned TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  // counter is held at zero outside power-down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (tick_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
  import slot_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       state_wr_i,
  input  logic [1:0] state_req_i,
  input  logic       card_present_i,
  input  logic       if_en_wr_i,
  input  logic       if_en_i,
  input  logic       expire_i,
  output slot_st_e   state_o,
  output logic       if_en_o,
  output logic       irq_o
);
  slot_st_e st_q, st_d, req;
  logic     refused, to_off, if_en_q, if_en_d, irq_q;

  assign req = slot_st_e'(state_req_i);

  always_comb begin
    st_d    = st_q;
    refused = 1'b0;
    if ((st_q == SLOT_HOLD || st_q == SLOT_READY) && !card_present_i) begin
      st_d = SLOT_PDOWN;
    end else if (state_wr_i) begin
      unique case (req)
        SLOT_OFF: st_d = SLOT_OFF;
        SLOT_HOLD, SLOT_READY: begin
          if (card_present_i) st_d = req;
          else begin
            st_d    = SLOT_PDOWN;
            refused = 1'b1;
          end
        end
        SLOT_PDOWN: if (st_q != SLOT_OFF) st_d = SLOT_PDOWN;
        default: st_d = st_q;
      endcase
    end else if (expire_i) begin
      st_d = SLOT_OFF;
    end
  end

  assign to_off = (st_q != SLOT_OFF) && (st_d == SLOT_OFF);

  always_comb begin
    if (to_off)          if_en_d = 1'b0;
    else if (if_en_wr_i) if_en_d = if_en_i;
    else                 if_en_d = if_en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SLOT_OFF;
      if_en_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      if_en_q <= if_en_d;
      irq_q   <= refused || to_off;
    end
  end

  assign state_o = st_q;
  assign if_en_o = if_en_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/slot_out_map.sv
module slot_out_map
  import slot_pwr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  slot_st_e          state_i,
  input  logic              if_en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              pwr_en_o,
  output logic              rst_no,
  output logic              clk_en_o,
  output logic [DATA_W-1:0] rd_data_o
);
  always_comb begin
    pwr_en_o  = 1'b1;
    rst_no    = 1'b0;
    clk_en_o  = 1'b0;
    rd_data_o = '0;
    unique case (state_i)
      SLOT_OFF:   pwr_en_o = 1'b0;
      SLOT_HOLD:  rd_data_o = '1;
      SLOT_READY: begin
        clk_en_o  = 1'b1;
        rst_no    = if_en_i;
        rd_data_o = rd_data_i;
      end
      SLOT_PDOWN: rd_data_o = '0;
      default:    pwr_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
  import slot_pwr_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned OFF_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              state_wr_i,
  input  logic [1:0]        state_req_i,
  input  logic              card_present_i,
  input  logic              if_en_wr_i,
  input  logic              if_en_i,
  input  logic              tick_i,
  output logic [1:0]        state_o,
  output logic              if_en_o,
  output logic              pwr_en_o,
  output logic              card_rst_no,
  output logic              card_clk_en_o,
  output logic              card_irq_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  slot_st_e st;
  logic     expire, en;

  slot_fsm i_fsm (
    .clk_i, .rst_ni, .state_wr_i, .state_req_i, .card_present_i,
    .if_en_wr_i, .if_en_i,
    .expire_i (expire),
    .state_o  (st),
    .if_en_o  (en),
    .irq_o    (card_irq_o)
  );

  slot_down_timer #(.TICKS(OFF_TICKS)) i_timer (
    .clk_i, .rst_ni,
    .run_i    (st == SLOT_PDOWN),
    .tick_i,
    .expire_o (expire)
  );

  slot_out_map #(.DATA_W(DATA_W)) i_map (
    .state_i   (st),
    .if_en_i   (en),
    .rd_data_i,
    .pwr_en_o,
    .rst_no    (card_rst_no),
    .clk_en_o  (card_clk_en_o),
    .rd_data_o
  );

  assign state_o = st;
  assign if_en_o = en;
endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              card_present_i,
  input logic [1:0]        state_o,
  input logic              if_en_o,
  input logic              pwr_en_o,
  input logic              card_rst_no,
  input logic              card_clk_en_o,
  input logic              card_irq_o,
  input logic [DATA_W-1:0] rd_data_o
);
  p_off_pins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 |-> !pwr_en_o && !card_clk_en_o && !card_rst_no && rd_data_o == '0);

  p_hold_pins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd1 |-> pwr_en_o && !card_clk_en_o && !card_rst_no && rd_data_o == '1);

  p_pdown_pins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 |-> pwr_en_o && !card_clk_en_o && !card_rst_no && rd_data_o == '0);

  p_release_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_no |-> card_clk_en_o && if_en_o && state_o == 2'd2);

  p_off_entry_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'd0 ##1 state_o == 2'd0 |-> card_irq_o && !if_en_o);

  p_removal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 || state_o == 2'd2) && !card_present_i |=> state_o == 2'd3);
endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i, .rst_ni, .card_present_i, .state_o, .if_en_o, .pwr_en_o,
  .card_rst_no, .card_clk_en_o, .card_irq_o, .rd_data_o
);

// File: tb/test_slot_pwr_seq.sv
module test_slot_pwr_seq;
  localparam int unsigned DW = 32;
  localparam int unsigned TK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic state_wr = 1'b0, card = 1'b1, en_wr = 1'b0, en_val = 1'b0, tick = 1'b0;
  logic [1:0] req = 2'd0;
  logic [DW-1:0] rdi = 32'h1234_5678;
  logic [1:0] st;
  logic en, pwr, rst_o, clk_en, irq;
  logic [DW-1:0] rdo;
  int vecs = 0, errs = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slot_pwr_seq #(.DATA_W(DW), .OFF_TICKS(TK)) i_slot_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .state_wr_i(state_wr), .state_req_i(req),
    .card_present_i(card), .if_en_wr_i(en_wr), .if_en_i(en_val), .tick_i(tick),
    .state_o(st), .if_en_o(en), .pwr_en_o(pwr), .card_rst_no(rst_o),
    .card_clk_en_o(clk_en), .card_irq_o(irq), .rd_data_i(rdi), .rd_data_o(rdo)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pins(string tag, logic [1:0] s, logic p, logic r, logic c, logic [31:0] d);
    chk({tag, " state"}, 32'(st), 32'(s));
    chk({tag, " pwr"},   32'(pwr), 32'(p));
    chk({tag, " rst_n"}, 32'(rst_o), 32'(r));
    chk({tag, " clk"},   32'(clk_en), 32'(c));
    chk({tag, " rd"},    rdo, d);
  endtask

  task automatic wr(logic [1:0] v);
    @(negedge clk); state_wr = 1'b1; req = v;
    @(negedge clk); state_wr = 1'b0;
  endtask

  task automatic set_en(logic v);
    @(negedge clk); en_wr = 1'b1; en_val = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    #1;
    pins("R1", 2'd0, 0, 0, 0, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 en", 32'(en), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pins("R2", 2'd0, 0, 0, 0, 0);
  endtask

  task automatic t_hold_ready;
    wr(2'd1);
    pins("R3", 2'd1, 1, 0, 0, 32'hffff_ffff);
    chk("R3 irq", 32'(irq), 0);
    wr(2'd2);
    pins("R10 en=0", 2'd2, 1, 0, 1, rdi);
    set_en(1'b1);
    pins("R4", 2'd2, 1, 1, 1, rdi);
    rdi = 32'hcafe_0001;
    #1 chk("R4 pass", rdo, 32'hcafe_0001);
    set_en(1'b0);
    chk("R10 rst", 32'(rst_o), 0);
    chk("R10 clk", 32'(clk_en), 1);
    ticks(TK + 2);
    chk("R8 ticks ignored", 32'(st), 2);
  endtask

  task automatic t_off_clear;
    set_en(1'b1);
    @(negedge clk); state_wr = 1'b1; req = 2'd0; en_wr = 1'b1; en_val = 1'b1;
    @(negedge clk); state_wr = 1'b0; en_wr = 1'b0;
    pins("R9", 2'd0, 0, 0, 0, 0);
    chk("R9 irq", 32'(irq), 1);
    chk("R9 en cleared", 32'(en), 0);
    @(negedge clk);
    chk("R9 pulse end", 32'(irq), 0);
  endtask

  task automatic t_off_ignore;
    wr(2'd3);
    chk("R11 req3", 32'(st), 0);
    chk("R11 irq3", 32'(irq), 0);
    wr(2'd0);
    chk("R11 req0", 32'(st), 0);
    chk("R11 irq0", 32'(irq), 0);
  endtask

  task automatic t_no_card;
    card = 1'b0;
    wr(2'd2);
    pins("R5", 2'd3, 1, 0, 0, 0);
    chk("R6 irq", 32'(irq), 1);
    @(negedge clk);
    chk("R6 pulse end", 32'(irq), 0);
    ticks(TK - 1);
    chk("R8 before last", 32'(st), 3);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R8 expired", 32'(st), 0);
    chk("R9 irq after timer", 32'(irq), 1);
    card = 1'b1;
  endtask

  task automatic t_removal;
    wr(2'd1);
    chk("R7 pre", 32'(st), 1);
    @(negedge clk); card = 1'b0;
    @(negedge clk);
    chk("R7 pdown", 32'(st), 3);
    chk("R7 no irq", 32'(irq), 0);
    card = 1'b1;
    ticks(TK);
    chk("R8 off", 32'(st), 0);
  endtask

  initial begin
    t_reset();
    t_hold_ready();
    t_off_clear();
    t_off_ignore();
    t_no_card();
    t_removal();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule